// File: doc/BRIEF.md
# Offset-State Decade Counter

This block is a synchronous divide-by-ten counter. Its core is a loadable binary counter that never visits the low codes. It steps through the top ten codes of its 4-bit range, which are 6 up to 15. When it leaves 15 it reloads 6 rather than rolling over to 0.

A small combinational translator turns the raw code into a decimal digit from 0 to 9. Code 6 reads as 0 and code 15 reads as 9. Codes below 6 never occur in normal operation, so the translator is free to return anything for them. A terminal flag marks the step that will wrap.

The counter moves only while its enable input is high. A synchronous clear puts it at the lowest legal code, so the digit reads 0 right after reset.

Top module: `offset_decade_counter`

## Requirements
- R1: When `rst` is high at a rising clock edge, `state_o` becomes 6 (binary 0110) and `digit_o` becomes 0 after that edge. Clear takes priority over `cnt_en`.
- R2: With `rst` low, `cnt_en` high and `state_o` below 15, the next edge raises `state_o` by exactly one.
- R3: With `rst` low, `cnt_en` high and `state_o` equal to 15 (binary 1111), the next edge loads 6, not 0.
- R4: With `rst` low and `cnt_en` low, `state_o` and `digit_o` keep their values across the edge.
- R5: For every raw code from 6 to 15, `digit_o` equals that code minus 6, with no delay: 6→0, 7→1, up to 15→9.
- R6: `term_o` is high exactly when `state_o` is 15 and `cnt_en` is high. It is combinational in both inputs.
- R7: After the first clear, `state_o` never leaves the range 6 to 15.
- R8: From any legal code, ten enabled edges bring `state_o` back to the same code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high clear to code 6 |
| cnt_en | input | 1 | Advance enable; when low the counter holds |
| state_o | output | 4 | Raw counter code, 6 to 15 |
| digit_o | output | 4 | Decoded decimal digit, 0 to 9 |
| term_o | output | 1 | High while code is 15 and enable is high |

## Verification
The bound checker watches several properties on every clock:
- The increment step, the 15-to-6 reload and the hold under low enable.
- The clear landing on code 6, and the code staying within 6 to 15.
- The digit following the code, and the terminal flag lining up with a digit of 9 and a wrap to 0.

Some behaviours need whole scenarios and are left to the bench:
- The complete code-to-digit table.
- The ten-step period.
- Clear beating enable in the same cycle.
- The terminal flag reacting to enable in mid-cycle.

// File: rtl/odc_pkg.sv
package odc_pkg;

    // Default geometry: 4-bit core, ten states at the top of the range
    localparam int DEF_WIDTH   = 4;
    localparam int DEF_MODULUS = 10;

    // Outputs carried through the top as one bundle
    typedef struct packed {
        logic [DEF_WIDTH-1:0] raw;
        logic [DEF_WIDTH-1:0] digit;
        logic                 term;
    } odc_view_t;

    // Control decision for the loadable core
    typedef enum logic [1:0] {
        ODC_HOLD = 2'b00,
        ODC_INCR = 2'b01,
        ODC_LOAD = 2'b10
    } odc_op_t;

    // Lowest legal code for a counter of width w and modulus m
    function automatic int odc_first(input int w, input int m);
        return (1 << w) - m;
    endfunction

    // Highest code of a w-bit counter
    function automatic int odc_last(input int w);
        return (1 << w) - 1;
    endfunction

endpackage

// File: rtl/odc_load_ctl.sv
module odc_load_ctl
    import odc_pkg::*;
#(
    parameter int WIDTH   = DEF_WIDTH,
    parameter int MODULUS = DEF_MODULUS
) (
    input  logic             rst,
    input  logic             cnt_en,
    input  logic [WIDTH-1:0] state,
    output odc_op_t          op,
    output logic [WIDTH-1:0] load_val,
    output logic             at_top
);
    localparam logic [WIDTH-1:0] FIRST_V = WIDTH'(odc_first(WIDTH, MODULUS));
    localparam logic [WIDTH-1:0] LAST_V  = WIDTH'(odc_last(WIDTH));

    assign at_top   = (state == LAST_V);
    assign load_val = FIRST_V;

    // Clear outranks counting; a wrap from the top code is a load of FIRST_V
    always_comb begin
        if (rst)
            op = ODC_LOAD;
        else if (cnt_en && at_top)
            op = ODC_LOAD;
        else if (cnt_en)
            op = ODC_INCR;
        else
            op = ODC_HOLD;
    end
endmodule

// File: rtl/odc_core.sv
module odc_core
    import odc_pkg::*;
#(
    parameter int WIDTH = DEF_WIDTH
) (
    input  logic             clk,
    input  odc_op_t          op,
    input  logic [WIDTH-1:0] load_val,
    output logic [WIDTH-1:0] state
);
    // Plain loadable binary counter
    always_ff @(posedge clk) begin
        unique case (op)
            ODC_LOAD: state <= load_val;
            ODC_INCR: state <= state + WIDTH'(1);
            default:  state <= state;
        endcase
    end
endmodule

// File: rtl/odc_decode.sv
module odc_decode
    import odc_pkg::*;
#(
    parameter int WIDTH   = DEF_WIDTH,
    parameter int MODULUS = DEF_MODULUS
) (
    input  logic [WIDTH-1:0] state,
    output logic [WIDTH-1:0] digit
);
    localparam int FIRST = odc_first(WIDTH, MODULUS);

    // One match line per legal code
    logic [MODULUS-1:0] hit;

    for (genvar g = 0; g < MODULUS; g++) begin : g_match
        assign hit[g] = (state == WIDTH'(FIRST + g));
    end

    // Illegal codes are don't-care; they fall through to a wrapped offset
    always_comb begin
        digit = state - WIDTH'(FIRST);
        for (int k = 0; k < MODULUS; k++) begin
            if (hit[k])
                digit = WIDTH'(k);
        end
    end
endmodule

// File: rtl/offset_decade_counter.sv
module offset_decade_counter
    import odc_pkg::*;
#(
    parameter int WIDTH   = DEF_WIDTH,
    parameter int MODULUS = DEF_MODULUS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cnt_en,
    output logic [WIDTH-1:0] state_o,
    output logic [WIDTH-1:0] digit_o,
    output logic             term_o
);
    odc_op_t          op;
    logic [WIDTH-1:0] load_val;
    logic [WIDTH-1:0] state;
    logic [WIDTH-1:0] digit;
    logic             at_top;

    odc_load_ctl #(.WIDTH(WIDTH), .MODULUS(MODULUS)) u_ctl (
        .rst      (rst),
        .cnt_en   (cnt_en),
        .state    (state),
        .op       (op),
        .load_val (load_val),
        .at_top   (at_top)
    );

    odc_core #(.WIDTH(WIDTH)) u_core (
        .clk      (clk),
        .op       (op),
        .load_val (load_val),
        .state    (state)
    );

    odc_decode #(.WIDTH(WIDTH), .MODULUS(MODULUS)) u_dec (
        .state (state),
        .digit (digit)
    );

    assign state_o = state;
    assign digit_o = digit;
    assign term_o  = at_top & cnt_en;
endmodule

// File: rtl/odc_checker.sv
module odc_checker
    import odc_pkg::*;
#(
    parameter int WIDTH   = DEF_WIDTH,
    parameter int MODULUS = DEF_MODULUS
) (
    input logic             clk,
    input logic             rst,
    input logic             cnt_en,
    input logic [WIDTH-1:0] state_o,
    input logic [WIDTH-1:0] digit_o,
    input logic             term_o
);
    localparam logic [WIDTH-1:0] FIRST_V = WIDTH'(odc_first(WIDTH, MODULUS));
    localparam logic [WIDTH-1:0] LAST_V  = WIDTH'(odc_last(WIDTH));
    localparam logic [WIDTH-1:0] TOPD_V  = WIDTH'(MODULUS - 1);

    logic prev_rst;
    always_ff @(posedge clk) prev_rst <= rst;

    // R1: the edge after a clear leaves code FIRST and digit 0
    a_r1_clear_lands: assert property (@(posedge clk) disable iff (rst)
        prev_rst |-> (state_o == FIRST_V && digit_o == '0));

    // R2: enabled step below the top adds one
    a_r2_step: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && state_o != LAST_V) |=> state_o == $past(state_o) + WIDTH'(1));

    // R3: enabled step from the top reloads FIRST
    a_r3_reload: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && state_o == LAST_V) |=> state_o == FIRST_V);

    // R4: disabled cycles hold
    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        !cnt_en |=> ($stable(state_o) && $stable(digit_o)));

    // R5: digit tracks code; lowest code reads zero, steps move the digit by one
    a_r5_zero: assert property (@(posedge clk) disable iff (rst)
        (state_o == FIRST_V) |-> digit_o == '0);
    a_r5_follow: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && state_o != LAST_V) |=> digit_o == $past(digit_o) + WIDTH'(1));

    // R6: flag coincides with digit 9 and precedes a wrap to 0
    a_r6_term_top: assert property (@(posedge clk) disable iff (rst)
        term_o |-> (digit_o == TOPD_V && cnt_en));
    a_r6_term_wrap: assert property (@(posedge clk) disable iff (rst)
        term_o |=> digit_o == '0);

    // R7: code stays in the legal window
    a_r7_range: assert property (@(posedge clk) disable iff (rst)
        state_o >= FIRST_V);
endmodule

bind offset_decade_counter odc_checker #(.WIDTH(WIDTH), .MODULUS(MODULUS)) u_odc_chk (
    .clk     (clk),
    .rst     (rst),
    .cnt_en  (cnt_en),
    .state_o (state_o),
    .digit_o (digit_o),
    .term_o  (term_o)
);

// File: tb/test_offset_decade_counter.sv
`timescale 1ns/1ps
module test_offset_decade_counter;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cnt_en = 1'b0;
    logic [3:0] state_o;
    logic [3:0] digit_o;
    logic       term_o;

    int checks = 0;
    int failures = 0;
    int exp_state = 6;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    offset_decade_counter i_offset_decade_counter (
        .clk     (clk),
        .rst     (rst),
        .cnt_en  (cnt_en),
        .state_o (state_o),
        .digit_o (digit_o),
        .term_o  (term_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Drive one cycle, check flag before the edge and code/digit after it
    task automatic cycle(input bit en, input bit clr, input string tag);
        @(negedge clk);
        cnt_en = en;
        rst    = clr;
        #0.5;
        check(term_o == (exp_state == 15 && en), {tag, " R6 term"}, int'(term_o),
              int'(exp_state == 15 && en));
        @(posedge clk);
        if (clr)       exp_state = 6;
        else if (en)   exp_state = (exp_state == 15) ? 6 : exp_state + 1;
        #1;
        check(state_o == exp_state, {tag, " state"}, int'(state_o), exp_state);
        check(digit_o == exp_state - 6, {tag, " R5 digit"}, int'(digit_o), exp_state - 6);
    endtask

    task automatic t_reset();
        cycle(1'b1, 1'b1, "R1 reset");
        check(state_o == 6 && digit_o == 0, "R1 clear to 6/0", int'(state_o), 6);
    endtask

    task automatic t_full_cycle();
        int start;
        start = exp_state;
        for (int i = 0; i < 10; i++) begin
            cycle(1'b1, 1'b0, "R2 R3 step");
            check(state_o >= 6, "R7 range", int'(state_o), 6);
        end
        check(int'(state_o) == start, "R8 period ten", int'(state_o), start);
    endtask

    task automatic t_hold();
        int held;
        held = exp_state;
        for (int i = 0; i < 4; i++) cycle(1'b0, 1'b0, "R4 hold");
        check(int'(state_o) == held, "R4 held code", int'(state_o), held);
    endtask

    task automatic t_wrap();
        while (exp_state != 15) cycle(1'b1, 1'b0, "R2 approach");
        cycle(1'b0, 1'b0, "R6 top idle");
        check(term_o == 1'b0, "R6 flag low with enable low", int'(term_o), 0);
        cycle(1'b1, 1'b0, "R3 wrap");
        check(state_o == 6, "R3 reload 6", int'(state_o), 6);
    endtask

    task automatic t_clear_priority();
        cycle(1'b1, 1'b0, "R2 pre");
        cycle(1'b1, 1'b0, "R2 pre");
        cycle(1'b1, 1'b1, "R1 clear over enable");
        check(state_o == 6, "R1 priority", int'(state_o), 6);
    endtask

    task automatic t_mixed();
        for (int i = 0; i < 23; i++) cycle(((i % 3) != 1), 1'b0, "R2 R4 mixed");
    endtask

    initial begin
        #100000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_full_cycle();
        t_hold();
        t_wrap();
        t_clear_priority();
        t_mixed();
        t_full_cycle();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule